// File: doc/BRIEF.md
# Four-Port GPIO Controller with Shared Falling-Edge Interrupt

This block serves a small microcontroller with four 4-bit pin groups. Group 0 is input-only, with its pull-ups always enabled; any of its pins can raise the interrupt. Groups 1 and 2 are configurable per pin as input or output. An input pin can be pulled up or left floating. An output pin can be push-pull or open-drain. Group 3 is a push-pull output-only group. The block holds its control state behind a register bus with a write strobe and a combinational read. For every pin it produces pad control signals (output enable, output data, pull-up enable).

All pin inputs pass through a two-stage synchronizer. A high-to-low change on any group 0 pin raises one shared sticky interrupt flag. A high-to-low change on a group 1 pin configured as input raises the same flag. Group 2 is a status-only input group and never raises the flag. There is no debounce, so every bounce that survives the synchronizer counts as an edge. Software finds the source by reading the input groups and then clears the flag by a register write.

Top module: `quad_port_gpio`

## Requirements
- R1: After reset, every group 1 and group 2 pin is an input with pull-up enabled: `pX_oe`=0000, `pX_do`=0000 and `pX_pu`=1111. `p3_do`=0000 and `irq`=0.
- R2: A 1-to-0 change on any `p0_in` pin sets `irq`, visible after the third rising clock edge following the change. A 0-to-1 change never sets it.
- R3: A 1-to-0 change on a group 1 pin sets `irq` only if that pin's direction bit is 0 (input). Changes on output pins are ignored.
- R4: No change on `p2_in` ever sets `irq`.
- R5: `irq` stays set until a write to address 10 with data bit 0 equal to 1. If a new edge is detected in the same cycle as that clear, `irq` stays set.
- R6: An output pin (direction bit 1) with configuration bit 0 is push-pull: `oe`=1 and `do` equals its data bit.
- R7: An output pin with configuration bit 1 is open-drain. When its data bit is 0 it has `oe`=1 and `do`=0. When its data bit is 1 it has `oe`=0 and `do`=0.
- R8: An input pin has `oe`=0 and `do`=0, and its `pu` equals its configuration bit (1 = pull-up, 0 = floating). An output pin always has `pu`=0.
- R9: The register map is: 0 = group 0 levels (read-only); 1/2/3 = group 1 direction/configuration/data; 4 = group 1 levels (read-only); 5/6/7 = group 2 direction/configuration/data; 8 = group 2 levels (read-only); 9 = group 3 data; 10 = bit 0 flag. Control registers read back what was written. Level registers show a pin change after the second rising edge.
- R10: A write that changes any group 1 direction bit blocks group 1 edges from setting `irq` for the three following cycles.
- R11: `p3_do` follows the group 3 data register, and `p0_pu` is always 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for `reg_addr` |
| p0_in | input | 4 | Group 0 pad levels |
| p0_pu | output | 4 | Group 0 pull-up enables |
| p1_in | input | 4 | Group 1 pad levels |
| p1_oe | output | 4 | Group 1 output enables |
| p1_do | output | 4 | Group 1 output data |
| p1_pu | output | 4 | Group 1 pull-up enables |
| p2_in | input | 4 | Group 2 pad levels |
| p2_oe | output | 4 | Group 2 output enables |
| p2_do | output | 4 | Group 2 output data |
| p2_pu | output | 4 | Group 2 pull-up enables |
| p3_do | output | 4 | Group 3 output data |
| irq | output | 1 | Shared sticky interrupt request |

## Verification
The pad-control logic is driven with a table of direction, configuration and data combinations, applied to both configurable groups. The table separates push-pull from open-drain drive, pull-up from floating inputs, and mixed per-pin settings within one group. The interrupt path is tried with falling and rising edges on each group, which separates the interrupting groups from the status-only group. A group 1 edge is applied once while the pin is an output and once while it is an input, to show that direction gates the interrupt. Two timed cases probe the remaining behaviour: a clear issued in the same cycle as a new edge, and an input that drops at the same moment its pin is switched to input, which exercises the settle window.

// File: rtl/quad_gpio_pkg.sv
package quad_gpio_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_P0_LVL = 4'd0;
  localparam logic [ADDR_W-1:0] A_P1_DIR = 4'd1;
  localparam logic [ADDR_W-1:0] A_P1_CFG = 4'd2;
  localparam logic [ADDR_W-1:0] A_P1_DAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_P1_LVL = 4'd4;
  localparam logic [ADDR_W-1:0] A_P2_DIR = 4'd5;
  localparam logic [ADDR_W-1:0] A_P2_CFG = 4'd6;
  localparam logic [ADDR_W-1:0] A_P2_DAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_P2_LVL = 4'd8;
  localparam logic [ADDR_W-1:0] A_P3_DAT = 4'd9;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd10;

  // Output enable of one pin: dir=1 output; cfg=1 open-drain.
  function automatic logic pin_oe(input logic dir, input logic cfg, input logic dat);
    return dir & (~cfg | ~dat);
  endfunction

  // Output data of one pin: only push-pull outputs drive a one.
  function automatic logic pin_do(input logic dir, input logic cfg, input logic dat);
    return dir & ~cfg & dat;
  endfunction

  // Pull-up of one pin: only inputs, selected by cfg.
  function automatic logic pin_pu(input logic dir, input logic cfg);
    return ~dir & cfg;
  endfunction

  // High-to-low change between two samples.
  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/qg_sync.sv
module qg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '1;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/qg_cfg_port.sv
module qg_cfg_port #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_cfg,
  input  logic         wr_dat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] dout,
  output logic [W-1:0] pu,
  output logic         dir_chg
);
  import quad_gpio_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      cfg_q <= '1;
      dat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_cfg) cfg_q <= wdata;
      if (wr_dat) dat_q <= wdata;
    end
  end

  assign dir_chg = wr_dir && (wdata != dir_q);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe[i]   = pin_oe(dir_q[i], cfg_q[i], dat_q[i]);
    assign dout[i] = pin_do(dir_q[i], cfg_q[i], dat_q[i]);
    assign pu[i]   = pin_pu(dir_q[i], cfg_q[i]);
  end
endmodule

// File: rtl/qg_edge_irq.sv
module qg_edge_irq #(
  parameter int W      = 4,
  parameter int SETTLE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] p0_s,
  input  logic [W-1:0] p1_s,
  input  logic [W-1:0] p1_dir,
  input  logic         p1_dir_chg,
  input  logic         clr,
  output logic [W-1:0] fall_p0,
  output logic [W-1:0] fall_p1,
  output logic         settle_act,
  output logic         any_fall,
  output logic         irq
);
  import quad_gpio_pkg::*;

  localparam int CW = $clog2(SETTLE + 1);

  logic [W-1:0]  hist_p0, hist_p1;
  logic [CW-1:0] settle_cnt;
  logic [W-1:0]  raw_p1;

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign fall_p0[i] = is_fall(hist_p0[i], p0_s[i]);
    assign raw_p1[i]  = is_fall(hist_p1[i], p1_s[i]);
  end

  assign settle_act = (settle_cnt != '0);
  assign fall_p1    = raw_p1 & ~p1_dir & {W{~settle_act}};
  assign any_fall   = (|fall_p0) | (|fall_p1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_p0    <= '1;
      hist_p1    <= '1;
      settle_cnt <= '0;
      irq        <= 1'b0;
    end else begin
      hist_p0 <= p0_s;
      hist_p1 <= p1_s;
      if (p1_dir_chg)      settle_cnt <= CW'(SETTLE);
      else if (settle_act) settle_cnt <= settle_cnt - 1'b1;
      irq <= any_fall | (irq & ~clr);
    end
  end
endmodule

// File: rtl/quad_port_gpio.sv
module quad_port_gpio #(
  parameter int PIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_we,
  input  logic [quad_gpio_pkg::ADDR_W-1:0]    reg_addr,
  input  logic [PIN_W-1:0]                    reg_wdata,
  output logic [PIN_W-1:0]                    reg_rdata,
  input  logic [PIN_W-1:0]                    p0_in,
  output logic [PIN_W-1:0]                    p0_pu,
  input  logic [PIN_W-1:0]                    p1_in,
  output logic [PIN_W-1:0]                    p1_oe,
  output logic [PIN_W-1:0]                    p1_do,
  output logic [PIN_W-1:0]                    p1_pu,
  input  logic [PIN_W-1:0]                    p2_in,
  output logic [PIN_W-1:0]                    p2_oe,
  output logic [PIN_W-1:0]                    p2_do,
  output logic [PIN_W-1:0]                    p2_pu,
  output logic [PIN_W-1:0]                    p3_do,
  output logic                                irq
);
  import quad_gpio_pkg::*;

  localparam int SETTLE = SYNC_STAGES + 1;

  logic [PIN_W-1:0] p0_s, p1_s, p2_s;
  logic [PIN_W-1:0] p1_dir, p1_cfg, p1_dat;
  logic [PIN_W-1:0] p2_dir, p2_cfg, p2_dat;
  logic [PIN_W-1:0] p3_dat;
  logic [PIN_W-1:0] fall_p0, fall_p1;
  logic             p1_dir_chg, p2_dir_chg;
  logic             settle_act, any_fall, clr;

  qg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_p0_i (.clk(clk), .rst_n(rst_n), .d(p0_in), .q(p0_s));
  qg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_p1_i (.clk(clk), .rst_n(rst_n), .d(p1_in), .q(p1_s));
  qg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_p2_i (.clk(clk), .rst_n(rst_n), .d(p2_in), .q(p2_s));

  qg_cfg_port #(.W(PIN_W)) port1_i (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(reg_we && reg_addr == A_P1_DIR),
    .wr_cfg(reg_we && reg_addr == A_P1_CFG),
    .wr_dat(reg_we && reg_addr == A_P1_DAT),
    .wdata(reg_wdata),
    .dir_q(p1_dir), .cfg_q(p1_cfg), .dat_q(p1_dat),
    .oe(p1_oe), .dout(p1_do), .pu(p1_pu), .dir_chg(p1_dir_chg)
  );

  qg_cfg_port #(.W(PIN_W)) port2_i (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(reg_we && reg_addr == A_P2_DIR),
    .wr_cfg(reg_we && reg_addr == A_P2_CFG),
    .wr_dat(reg_we && reg_addr == A_P2_DAT),
    .wdata(reg_wdata),
    .dir_q(p2_dir), .cfg_q(p2_cfg), .dat_q(p2_dat),
    .oe(p2_oe), .dout(p2_do), .pu(p2_pu), .dir_chg(p2_dir_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            p3_dat <= '0;
    else if (reg_we && reg_addr == A_P3_DAT) p3_dat <= reg_wdata;
  end

  assign clr = reg_we && (reg_addr == A_FLAG) && reg_wdata[0];

  qg_edge_irq #(.W(PIN_W), .SETTLE(SETTLE)) irq_i (
    .clk(clk), .rst_n(rst_n),
    .p0_s(p0_s), .p1_s(p1_s), .p1_dir(p1_dir), .p1_dir_chg(p1_dir_chg),
    .clr(clr),
    .fall_p0(fall_p0), .fall_p1(fall_p1), .settle_act(settle_act),
    .any_fall(any_fall), .irq(irq)
  );

  assign p0_pu = '1;
  assign p3_do = p3_dat;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_P0_LVL: reg_rdata = p0_s;
      A_P1_DIR: reg_rdata = p1_dir;
      A_P1_CFG: reg_rdata = p1_cfg;
      A_P1_DAT: reg_rdata = p1_dat;
      A_P1_LVL: reg_rdata = p1_s;
      A_P2_DIR: reg_rdata = p2_dir;
      A_P2_CFG: reg_rdata = p2_cfg;
      A_P2_DAT: reg_rdata = p2_dat;
      A_P2_LVL: reg_rdata = p2_s;
      A_P3_DAT: reg_rdata = p3_dat;
      A_FLAG:   reg_rdata = {{(PIN_W-1){1'b0}}, irq};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qg_checker.sv
module qg_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         any_fall,
  input logic         clr,
  input logic [W-1:0] fall_p0,
  input logic         settle_act,
  input logic [W-1:0] p0_pu,
  input logic [W-1:0] p1_oe,
  input logic [W-1:0] p1_do,
  input logic [W-1:0] p1_pu,
  input logic [W-1:0] p1_dir,
  input logic [W-1:0] p1_cfg,
  input logic [W-1:0] p2_oe,
  input logic [W-1:0] p2_pu,
  input logic [W-1:0] p2_dir
);
  // R2, R3, R4: the flag only rises after a detected edge
  a_r2_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_fall));

  // R5: an edge always leaves the flag set, even against a clear
  a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_fall |=> irq);

  // R5: a clear without an edge drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_fall) |=> !irq);

  // R5: without edge or clear the flag holds
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !any_fall) |=> $stable(irq));

  // R10: in the settle window only group 0 can raise the flag
  a_r10_settle_block: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_act && fall_p0 == '0 && !irq) |=> !irq);

  // R7: an open-drain pin never drives high
  a_r7_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_oe & p1_do & p1_cfg) == '0);

  // R8: input pins never drive, output pins never pull up
  a_r8_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((p1_oe & ~p1_dir) == '0) && ((p2_oe & ~p2_dir) == '0));

  a_r8_no_pu_on_out: assert property (@(posedge clk) disable iff (!rst_n)
    ((p1_pu & p1_dir) == '0) && ((p2_pu & p2_dir) == '0));

  // R11: group 0 pull-ups always on
  a_r11_p0_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    p0_pu == '1);
endmodule

bind quad_port_gpio qg_checker #(.W(PIN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .any_fall(any_fall), .clr(clr),
  .fall_p0(fall_p0), .settle_act(settle_act), .p0_pu(p0_pu),
  .p1_oe(p1_oe), .p1_do(p1_do), .p1_pu(p1_pu), .p1_dir(p1_dir), .p1_cfg(p1_cfg),
  .p2_oe(p2_oe), .p2_pu(p2_pu), .p2_dir(p2_dir)
);

// File: tb/quad_port_gpio_tb_top.sv
module quad_port_gpio_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [3:0] reg_wdata = 4'd0;
  logic [3:0] reg_rdata;
  logic [3:0] p0_in = 4'hF, p1_in = 4'hF, p2_in = 4'hF;
  logic [3:0] p0_pu, p1_oe, p1_do, p1_pu, p2_oe, p2_do, p2_pu, p3_do;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_port_gpio dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .p0_in(p0_in), .p0_pu(p0_pu),
    .p1_in(p1_in), .p1_oe(p1_oe), .p1_do(p1_do), .p1_pu(p1_pu),
    .p2_in(p2_in), .p2_oe(p2_oe), .p2_do(p2_do), .p2_pu(p2_pu),
    .p3_do(p3_do), .irq(irq)
  );

  // {dir, cfg, dat, exp_oe, exp_do, exp_pu}
  localparam logic [23:0] VEC [6] = '{
    {4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b1111},
    {4'b0000, 4'b0101, 4'b1111, 4'b0000, 4'b0000, 4'b0101},
    {4'b1111, 4'b0000, 4'b1010, 4'b1111, 4'b1010, 4'b0000},
    {4'b1111, 4'b1111, 4'b1010, 4'b0101, 4'b0000, 4'b0000},
    {4'b1100, 4'b1010, 4'b0110, 4'b1100, 4'b0100, 4'b0010},
    {4'b0011, 4'b0011, 4'b0011, 4'b0000, 4'b0000, 4'b0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [3:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state, R11 group 0 pull-ups
    check("R1 p1_oe", p1_oe, 4'h0);
    check("R1 p1_do", p1_do, 4'h0);
    check("R1 p1_pu", p1_pu, 4'hF);
    check("R1 p2_oe", p2_oe, 4'h0);
    check("R1 p2_pu", p2_pu, 4'hF);
    check("R1 p3_do", p3_do, 4'h0);
    check("R1 irq", irq, 1'b0);
    check("R11 p0_pu", p0_pu, 4'hF);

    // R6 R7 R8 drive table on both configurable groups
    for (int g = 0; g < 2; g++) begin
      for (int v = 0; v < 6; v++) begin
        logic [3:0] base;
        base = (g == 0) ? 4'd1 : 4'd5;
        wr(base,        VEC[v][23:20]);
        wr(base + 4'd1, VEC[v][19:16]);
        wr(base + 4'd2, VEC[v][15:12]);
        if (g == 0) begin
          check($sformatf("R6/R7 p1_oe vec%0d", v), p1_oe, VEC[v][11:8]);
          check($sformatf("R6/R7 p1_do vec%0d", v), p1_do, VEC[v][7:4]);
          check($sformatf("R8 p1_pu vec%0d", v), p1_pu, VEC[v][3:0]);
        end else begin
          check($sformatf("R6/R7 p2_oe vec%0d", v), p2_oe, VEC[v][11:8]);
          check($sformatf("R6/R7 p2_do vec%0d", v), p2_do, VEC[v][7:4]);
          check($sformatf("R8 p2_pu vec%0d", v), p2_pu, VEC[v][3:0]);
        end
      end
    end
    check("R3 no irq from config writes", irq, 1'b0);

    // restore inputs with pull-up
    wr(4'd1, 4'h0); wr(4'd2, 4'hF); wr(4'd5, 4'h0); wr(4'd6, 4'hF);
    wait_n(4);

    // R9 readback, R11 group 3
    wr(4'd9, 4'hA);
    check("R11 p3_do", p3_do, 4'hA);
    rd_check("R9 read p3 data", 4'd9, 4'hA);
    rd_check("R9 read p1 dir", 4'd1, 4'h0);
    rd_check("R9 read p1 cfg", 4'd2, 4'hF);
    rd_check("R9 read p2 data", 4'd7, 4'h3);
    rd_check("R9 read p0 level", 4'd0, 4'hF);

    // R2 falling edge on group 0
    p0_in = 4'b1110;
    wait_n(2);
    check("R2 not yet after two edges", irq, 1'b0);
    wait_n(1);
    check("R2 p0 fall sets irq", irq, 1'b1);
    rd_check("R9 read flag", 4'd10, 4'h1);
    wr(4'd10, 4'h1);
    check("R5 clear drops irq", irq, 1'b0);
    p0_in = 4'b1111;
    wait_n(4);
    check("R2 rising edge ignored", irq, 1'b0);

    // R5 sticky and clear racing a new edge
    p0_in = 4'b1110;
    wait_n(3);
    check("R5 flag set before race", irq, 1'b1);
    wait_n(2);
    check("R5 flag sticky", irq, 1'b1);
    p0_in = 4'b1100;                 // fall seen between edges k+1 and k+2
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd10; reg_wdata = 4'h1;
    @(negedge clk);
    reg_we = 1'b0;
    check("R5 edge wins over clear", irq, 1'b1);
    wr(4'd10, 4'h1);
    check("R5 clear after race", irq, 1'b0);
    p0_in = 4'hF;
    wait_n(4);

    // R4 group 2 status only, R9 level read
    p2_in = 4'b0101;
    wait_n(2);
    rd_check("R9 read p2 level", 4'd8, 4'b0101);
    wait_n(2);
    check("R4 p2 fall ignored", irq, 1'b0);

    // R3 group 1 input pin
    p1_in = 4'b0111;
    wait_n(3);
    check("R3 p1 input fall sets irq", irq, 1'b1);
    wr(4'd10, 4'h1);
    p1_in = 4'hF;
    wait_n(4);
    check("R3 p1 rise ignored", irq, 1'b0);

    // R3 group 1 output pins ignored
    wr(4'd1, 4'hF);
    wait_n(5);
    p1_in = 4'h0;
    wait_n(4);
    check("R3 p1 output fall ignored", irq, 1'b0);
    rd_check("R9 read p1 level while output", 4'd4, 4'h0);

    // R10 settle window on direction change
    p1_in = 4'hF;
    wait_n(4);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 4'h0;
    p1_in = 4'h0;
    @(negedge clk);
    reg_we = 1'b0;
    wait_n(4);
    check("R10 no irq in settle window", irq, 1'b0);
    p1_in = 4'hF;
    wait_n(4);
    p1_in = 4'b1110;
    wait_n(3);
    check("R10 edges count after window", irq, 1'b1);

    finish_run();
  end
endmodule